// File: doc/BRIEF.md
# Radix Page Table Walker

This block turns a 64-bit effective address into a physical address by walking a tree of page directories kept in memory. A caller presents one translate request at a time. With it come the access attributes (privileged, instruction fetch, store) and the root of the tree: a root directory base, a root directory size and two tree-size fields. The walker first checks that the address lies inside the tree. It then reads one 64-bit entry per level through a request/acknowledge memory port until it reaches a leaf, an invalid entry or a malformed level.

The walk ends with a one-cycle completion pulse. With that pulse comes either a physical address or exactly one error flag: segment, bad tree, missing entry, permission, or reference/change. The walker does not cache translations and never writes entries back.

In this text bit numbers count from 0 at the least significant bit of a 64-bit word.

Top module: `rw_walker`

## Requirements
- R1: The tree spans T = ({tree_hi, tree_lo} as a 5-bit value) + 31 address bits. The walk fails with the segment flag and makes no memory read when ea[63] differs from ea[62], or when any bit ea[k] with 31 <= k <= 61 and k >= T is set.
- R2: The untranslated bit count starts at T - 12. A root size below 5, above 16, or above that count gives the bad-tree flag with no memory read.
- R3: At each level with size S, the count shrinks by S to a new value N. The entry is read at base + 8 * ea[12+N +: S]. The root uses root_base; a deeper level uses the directory entry with bits 63..60 and 7..0 cleared.
- R4: An entry whose bit 63 (valid) is 0, at any level, ends the walk with the missing-entry flag.
- R5: A directory entry (bit 62 = 0) gives the next size in bits 4..0. That size is checked against the rule of R2, using the remaining count, and a failure gives the bad-tree flag.
- R6: A leaf (bit 62 = 1) is rejected with the permission flag under any of these conditions. The access is unprivileged and bit 3 is set. Or a data access has neither bit 1 (write) set nor bit 2 (read) set with no store. Or a fetch has bit 0 (execute) clear or bit 5 (cache-inhibit) set.
- R7: A leaf that passes R6 gets the reference/change flag unless bit 8 (reference) is set and either bit 7 (change) is set or the access is a load. When both checks fail, only the permission flag is raised.
- R8: A successful walk returns pa = {bits 56..12 of the leaf, 12 zero bits} ORed with the low 12+N bits of the address, where N is the count left after the leaf's level.
- R9: done is high for exactly one cycle per accepted request, with at most one error flag. Flags are low when done is low. req_ready is high only while idle, and a request raised while busy is ignored.
- R10: mem_req stays high with a stable mem_addr until mem_ack is seen, for any acknowledge latency.
- R11: After reset: req_ready = 1, done = 0, mem_req = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| req_valid | input | 1 | Translate request, taken while req_ready is high |
| req_ready | output | 1 | Walker idle |
| req_ea | input | 64 | Effective address |
| req_priv | input | 1 | Privileged access |
| req_ifetch | input | 1 | Instruction fetch (else data access) |
| req_store | input | 1 | Data store |
| root_base | input | 64 | Root directory base, 8-byte aligned |
| root_tree_hi | input | 2 | Upper tree-size field |
| root_tree_lo | input | 3 | Lower tree-size field |
| root_size | input | 5 | Root directory size, log2 of its entry count |
| mem_req | output | 1 | Entry read request |
| mem_addr | output | 64 | Entry byte address |
| mem_ack | input | 1 | Read data valid |
| mem_rdata | input | 64 | Entry read |
| done | output | 1 | Walk finished (one cycle) |
| pa | output | 64 | Physical address, valid with done and no flag |
| err_seg | output | 1 | Address outside the tree |
| err_badtree | output | 1 | Level size out of range |
| err_noent | output | 1 | Invalid entry reached |
| err_perm | output | 1 | Access not allowed |
| err_rc | output | 1 | Reference/change state forbids access |

## Verification
The permission test and the reference/change test are evaluated on the same leaf in the same cycle. The bench provokes both together with leaves that deny the access and also lack the reference or change bit, and checks that only the permission flag rises with done. A second overlap is a new request arriving while a walk is in flight. The bench raises req_valid mid-walk and confirms that req_ready stays low, that exactly one done appears, and that its result belongs to the first request.

// File: rtl/rw_pkg.sv
// Package: shared constants and types of the radix walker.
// Assumes 64-bit entries and addresses; field positions are fixed by the entry format.
package rw_pkg;
    localparam int EA_W        = 64;
    localparam int PAGE_BITS   = 12;
    localparam int SEG_LO      = 31;
    localparam int SEG_HI      = 61;
    localparam int ROOT_OFFS   = SEG_LO - PAGE_BITS;
    localparam int SIZE_W      = 5;
    localparam int REM_W       = 6;
    localparam int RPN_W       = 45;
    localparam int MIN_LVL     = 5;
    localparam int MAX_LVL     = 16;
    localparam logic [EA_W-1:0] DIR_BASE_MASK = 64'h0FFF_FFFF_FFFF_FF00;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_START,
        ST_FETCH,
        ST_DECODE
    } walk_state_e;

    typedef struct packed {
        logic seg;
        logic badtree;
        logic noent;
        logic perm;
        logic rc;
    } walk_err_t;
endpackage

// File: rtl/rw_seg_check.sv
// Segment check: flags an address outside the tree span.
// Assumes tree_bits is the 5-bit tree-size value (span = tree_bits + 31 bits).
module rw_seg_check
    import rw_pkg::*;
#(
    parameter int LO = SEG_LO,
    parameter int HI = SEG_HI,
    parameter int TW = SIZE_W
) (
    input  logic [EA_W-1:LO] ea_hi,
    input  logic [TW-1:0]    tree_bits,
    output logic             seg_err
);
    localparam int SPAN = HI - LO + 1;

    logic [SPAN-1:0] over;

    // One flag per checked bit: set and above the tree span.
    genvar g;
    generate
        for (g = 0; g < SPAN; g++) begin : g_bit
            assign over[g] = ea_hi[LO+g] & ({1'b0, tree_bits} <= (TW+1)'(g));
        end
    endgenerate

    // Sign bits must agree and no out-of-span bit may be set.
    assign seg_err = (ea_hi[EA_W-1] != ea_hi[EA_W-2]) | (|over);
endmodule

// File: rtl/rw_level_calc.sv
// Level step: validates a level size, shrinks the remaining bit count and forms the entry address.
// Assumes base is 8-byte aligned; result is meaningless when bad is set.
module rw_level_calc
    import rw_pkg::*;
#(
    parameter int AW    = EA_W,
    parameter int SW    = SIZE_W,
    parameter int RW    = REM_W,
    parameter int PB    = PAGE_BITS,
    parameter int MINSZ = MIN_LVL,
    parameter int MAXSZ = MAX_LVL
) (
    input  logic [AW-1:0] ea,
    input  logic [AW-1:0] base,
    input  logic [SW-1:0] size,
    input  logic [RW-1:0] rem_in,
    output logic          bad,
    output logic [RW-1:0] rem_out,
    output logic [AW-1:0] entry_addr
);
    localparam int SHW = RW + 1;

    logic [SHW-1:0] shamt;
    logic [AW-1:0]  idx;

    // Size legality and index extraction for this level.
    always_comb begin
        bad        = (size < SW'(MINSZ)) || (size > SW'(MAXSZ)) ||
                     (RW'(size) > rem_in);
        rem_out    = rem_in - RW'(size);
        shamt      = SHW'(PB) + SHW'(rem_out);
        idx        = (ea >> shamt) & ((AW'(1) << size) - AW'(1));
        entry_addr = base + (idx << 3);
    end
endmodule

// File: rtl/rw_leaf_check.sv
// Leaf evaluation: access rights, reference/change state and physical address.
// Assumes the caller raises at most one of the two flags as reported; permission wins.
module rw_leaf_check
    import rw_pkg::*;
#(
    parameter int AW = EA_W,
    parameter int RW = REM_W,
    parameter int PB = PAGE_BITS,
    parameter int NW = RPN_W
) (
    input  logic [AW-1:0] ea,
    input  logic [RW-1:0] rem,
    input  logic [NW-1:0] rpn,
    input  logic [3:0]    prot,      // [3] privileged-only, [2] read, [1] write, [0] execute
    input  logic          ci,
    input  logic          ref_b,
    input  logic          chg_b,
    input  logic          priv,
    input  logic          ifetch,
    input  logic          store,
    output logic          perm_err,
    output logic          rc_err,
    output logic [AW-1:0] pa
);
    localparam int SHW = RW + 1;

    logic          perm_ok;
    logic          rc_ok;
    logic [SHW-1:0] off_bits;
    logic [AW-1:0]  off_mask;

    // Rights check, then R/C check gated by rights.
    always_comb begin
        perm_ok  = (priv || !prot[3]) &&
                   (ifetch ? (prot[0] && !ci) : (prot[1] || (prot[2] && !store)));
        rc_ok    = ref_b && (chg_b || !store);
        perm_err = !perm_ok;
        rc_err   = perm_ok && !rc_ok;
    end

    // Physical address: page number ORed with the untranslated offset.
    always_comb begin
        off_bits = SHW'(PB) + SHW'(rem);
        off_mask = (AW'(1) << off_bits) - AW'(1);
        pa       = {{(AW-NW-PB){1'b0}}, rpn, {PB{1'b0}}} | (ea & off_mask);
    end
endmodule

// File: rtl/rw_walker.sv
// Radix walker top: accepts one translate request while idle, checks the segment,
// reads one entry per level and reports a physical address or one error flag with a done pulse.
// Assumes memory answers every mem_req with one mem_ack and holds mem_rdata in that cycle.
module rw_walker
    import rw_pkg::*;
#(
    parameter int AW = EA_W,
    parameter int SW = SIZE_W,
    parameter int RW = REM_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req_valid,
    output logic          req_ready,
    input  logic [AW-1:0] req_ea,
    input  logic          req_priv,
    input  logic          req_ifetch,
    input  logic          req_store,
    input  logic [AW-1:0] root_base,
    input  logic [1:0]    root_tree_hi,
    input  logic [2:0]    root_tree_lo,
    input  logic [SW-1:0] root_size,
    output logic          mem_req,
    output logic [AW-1:0] mem_addr,
    input  logic          mem_ack,
    input  logic [AW-1:0] mem_rdata,
    output logic          done,
    output logic [AW-1:0] pa,
    output logic          err_seg,
    output logic          err_badtree,
    output logic          err_noent,
    output logic          err_perm,
    output logic          err_rc
);
    localparam int VALID_BIT = AW - 1;
    localparam int LEAF_BIT  = AW - 2;

    walk_state_e   state;
    logic [AW-1:0] ea_q;
    logic          priv_q, ifetch_q, store_q;
    logic [AW-1:0] base_q;
    logic [4:0]    tree_q;
    logic [SW-1:0] size_q;
    logic [RW-1:0] rem_q;
    logic [AW-1:0] addr_q;
    logic [AW-1:0] entry_q;
    logic          done_q;
    walk_err_t     err_q;
    logic [AW-1:0] pa_q;

    logic [AW-1:0] lc_base;
    logic [SW-1:0] lc_size;
    logic [RW-1:0] lc_rem;
    logic          lvl_bad;
    logic [RW-1:0] lvl_rem;
    logic [AW-1:0] lvl_addr;
    logic          seg_err;
    logic          leaf_perm, leaf_rc;
    logic [AW-1:0] leaf_pa;
    logic          unused_bits;

    assign unused_bits = ^{entry_q[61:60], entry_q[6]};

    rw_seg_check #(.LO(SEG_LO), .HI(SEG_HI), .TW(5)) i_seg (
        .ea_hi    (ea_q[AW-1:SEG_LO]),
        .tree_bits(tree_q),
        .seg_err  (seg_err)
    );

    // Level inputs: root fields at start, previous directory entry afterwards.
    always_comb begin
        if (state == ST_START) begin
            lc_base = base_q;
            lc_size = size_q;
            lc_rem  = RW'(tree_q) + RW'(ROOT_OFFS);
        end else begin
            lc_base = entry_q & DIR_BASE_MASK;
            lc_size = entry_q[SW-1:0];
            lc_rem  = rem_q;
        end
    end

    rw_level_calc #(.AW(AW), .SW(SW), .RW(RW)) i_lvl (
        .ea        (ea_q),
        .base      (lc_base),
        .size      (lc_size),
        .rem_in    (lc_rem),
        .bad       (lvl_bad),
        .rem_out   (lvl_rem),
        .entry_addr(lvl_addr)
    );

    rw_leaf_check #(.AW(AW), .RW(RW)) i_leaf (
        .ea      (ea_q),
        .rem     (rem_q),
        .rpn     (entry_q[56:12]),
        .prot    (entry_q[3:0]),
        .ci      (entry_q[5]),
        .ref_b   (entry_q[8]),
        .chg_b   (entry_q[7]),
        .priv    (priv_q),
        .ifetch  (ifetch_q),
        .store   (store_q),
        .perm_err(leaf_perm),
        .rc_err  (leaf_rc),
        .pa      (leaf_pa)
    );

    // Walk sequencer: request capture, level stepping and result registration.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= ST_IDLE;
            ea_q     <= '0;
            priv_q   <= 1'b0;
            ifetch_q <= 1'b0;
            store_q  <= 1'b0;
            base_q   <= '0;
            tree_q   <= '0;
            size_q   <= '0;
            rem_q    <= '0;
            addr_q   <= '0;
            entry_q  <= '0;
            done_q   <= 1'b0;
            err_q    <= '0;
            pa_q     <= '0;
        end else begin
            done_q <= 1'b0;
            err_q  <= '0;
            pa_q   <= '0;
            unique case (state)
                ST_IDLE: begin
                    if (req_valid) begin
                        ea_q     <= req_ea;
                        priv_q   <= req_priv;
                        ifetch_q <= req_ifetch;
                        store_q  <= req_store;
                        base_q   <= root_base;
                        tree_q   <= {root_tree_hi, root_tree_lo};
                        size_q   <= root_size;
                        state    <= ST_START;
                    end
                end
                ST_START: begin
                    if (seg_err) begin
                        done_q    <= 1'b1;
                        err_q.seg <= 1'b1;
                        state     <= ST_IDLE;
                    end else if (lvl_bad) begin
                        done_q        <= 1'b1;
                        err_q.badtree <= 1'b1;
                        state         <= ST_IDLE;
                    end else begin
                        addr_q <= lvl_addr;
                        rem_q  <= lvl_rem;
                        state  <= ST_FETCH;
                    end
                end
                ST_FETCH: begin
                    if (mem_ack) begin
                        entry_q <= mem_rdata;
                        state   <= ST_DECODE;
                    end
                end
                ST_DECODE: begin
                    if (!entry_q[VALID_BIT]) begin
                        done_q      <= 1'b1;
                        err_q.noent <= 1'b1;
                        state       <= ST_IDLE;
                    end else if (entry_q[LEAF_BIT]) begin
                        done_q     <= 1'b1;
                        err_q.perm <= leaf_perm;
                        err_q.rc   <= leaf_rc;
                        pa_q       <= (leaf_perm || leaf_rc) ? '0 : leaf_pa;
                        state      <= ST_IDLE;
                    end else if (lvl_bad) begin
                        done_q        <= 1'b1;
                        err_q.badtree <= 1'b1;
                        state         <= ST_IDLE;
                    end else begin
                        addr_q <= lvl_addr;
                        rem_q  <= lvl_rem;
                        state  <= ST_FETCH;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    assign req_ready   = (state == ST_IDLE);
    assign mem_req     = (state == ST_FETCH);
    assign mem_addr    = addr_q;
    assign done        = done_q;
    assign pa          = pa_q;
    assign err_seg     = err_q.seg;
    assign err_badtree = err_q.badtree;
    assign err_noent   = err_q.noent;
    assign err_perm    = err_q.perm;
    assign err_rc      = err_q.rc;

    // R9: completion lasts a single cycle.
    a_r9_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R9: at most one error flag per completion.
    a_r9_one_flag: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> ($countones({err_seg, err_badtree, err_noent, err_perm, err_rc}) <= 1));

    // R9: flags only accompany done.
    a_r9_flags_with_done: assert property (@(posedge clk) disable iff (!rst_n)
        !done |-> ({err_seg, err_badtree, err_noent, err_perm, err_rc} == 5'b0));

    // R10: a pending read keeps its request and address.
    a_r10_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr)));

    // R9: an idle walker issues no reads.
    a_r9_idle_no_read: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> !mem_req);
endmodule

// File: tb/test_rw_walker.sv
// Scoreboard bench for rw_walker: the driver queues expected results, the monitor checks each done.
module test_rw_walker;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [63:0] req_ea = '0;
    logic        req_priv = 1'b0, req_ifetch = 1'b0, req_store = 1'b0;
    logic [63:0] root_base = '0;
    logic [1:0]  root_tree_hi = '0;
    logic [2:0]  root_tree_lo = '0;
    logic [4:0]  root_size = '0;
    logic        mem_req;
    logic [63:0] mem_addr;
    logic        mem_ack;
    logic [63:0] mem_rdata;
    logic        done;
    logic [63:0] pa;
    logic        err_seg, err_badtree, err_noent, err_perm, err_rc;

    localparam logic [63:0] ROOT = 64'h1_0000;
    localparam logic [63:0] L2   = 64'h2_0000;
    localparam logic [63:0] EA   = 64'h1234_5678;

    typedef struct packed {
        logic [4:0]  err;   // {seg, badtree, noent, perm, rc}
        logic [63:0] pa;
        logic [7:0]  reads;
    } exp_t;

    exp_t        exp_q[$];
    string       tag_q[$];
    logic [63:0] mem_m [logic [63:0]];
    int          total = 0, fails = 0;
    int          lat = 0;
    int          wcnt = 0;
    int          reads = 0;
    int          done_cnt = 0, push_cnt = 0;
    logic [63:0] first_addr = '0;

    always #4 clk = ~clk;

    rw_walker i_rw_walker (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_ea(req_ea), .req_priv(req_priv), .req_ifetch(req_ifetch), .req_store(req_store),
        .root_base(root_base), .root_tree_hi(root_tree_hi), .root_tree_lo(root_tree_lo),
        .root_size(root_size), .mem_req(mem_req), .mem_addr(mem_addr), .mem_ack(mem_ack),
        .mem_rdata(mem_rdata), .done(done), .pa(pa), .err_seg(err_seg),
        .err_badtree(err_badtree), .err_noent(err_noent), .err_perm(err_perm), .err_rc(err_rc)
    );

    function automatic logic [63:0] rd(input logic [63:0] a);
        if (mem_m.exists(a)) return mem_m[a];
        return 64'd0;
    endfunction

    function automatic logic [63:0] dir(input logic [63:0] base, input logic [4:0] nls);
        return (64'd1 << 63) | base | 64'(nls);
    endfunction

    function automatic logic [63:0] leaf(input logic [44:0] rpn, input logic r, c,
                                         input logic [1:0] att, input logic [3:0] prot);
        return (64'd3 << 62) | (64'(rpn) << 12) | (64'(r) << 8) | (64'(c) << 7) |
               (64'(att) << 4) | 64'(prot);
    endfunction

    // Reference model written from the requirements.
    function automatic exp_t model(input logic [63:0] ea, input logic priv, ifetch, store,
                                   input logic [4:0] tb, input logic [4:0] size);
        exp_t        r;
        int          rem, s;
        logic [63:0] b, e, idx;
        logic        pok;
        r = '0;
        if (ea[63] != ea[62]) begin r.err = 5'b10000; return r; end
        for (int k = 31; k <= 61; k++)
            if (ea[k] && (k - 31) >= int'(tb)) begin r.err = 5'b10000; return r; end
        rem = int'(tb) + 19;
        b   = ROOT;
        s   = int'(size);
        for (int lv = 0; lv < 12; lv++) begin
            if (s < 5 || s > 16 || s > rem) begin r.err = 5'b01000; return r; end
            rem = rem - s;
            idx = (ea >> (12 + rem)) & ((64'd1 << s) - 64'd1);
            e   = rd(b + (idx << 3));
            r.reads = r.reads + 8'd1;
            if (!e[63]) begin r.err = 5'b00100; return r; end
            if (e[62]) begin
                pok = (priv || !e[3]) &&
                      (ifetch ? (e[0] && !e[5]) : (e[1] || (e[2] && !store)));
                if (!pok) r.err = 5'b00010;
                else if (!(e[8] && (e[7] || !store))) r.err = 5'b00001;
                else r.pa = {7'd0, e[56:12], 12'd0} | (ea & ((64'd1 << (12 + rem)) - 64'd1));
                return r;
            end
            b = e & 64'h0FFF_FFFF_FFFF_FF00;
            s = int'(e[4:0]);
        end
        return r;
    endfunction

    task automatic chk(input bit ok, input string tag, input logic [63:0] act, exp);
        total++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Memory responder with programmable acknowledge latency.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mem_ack   <= 1'b0;
            mem_rdata <= '0;
            wcnt      <= 0;
        end else if (mem_req && !mem_ack) begin
            if (wcnt >= lat) begin
                mem_ack   <= 1'b1;
                mem_rdata <= rd(mem_addr);
                wcnt      <= 0;
            end else begin
                wcnt <= wcnt + 1;
            end
        end else begin
            mem_ack <= 1'b0;
        end
    end

    // Read counter per walk.
    always @(posedge clk) begin
        if (rst_n && mem_req && mem_ack) begin
            if (reads == 0) first_addr = mem_addr;
            reads = reads + 1;
        end
    end

    // Monitor: pop and compare on each done.
    always @(negedge clk) begin
        if (rst_n && done) begin
            if (exp_q.size() == 0) begin
                chk(1'b0, "R9 done without request", 64'd1, 64'd0);
            end else begin
                exp_t  x;
                string t;
                x = exp_q.pop_front();
                t = tag_q.pop_front();
                chk({err_seg, err_badtree, err_noent, err_perm, err_rc} == x.err,
                    {t, " flags"}, 64'({err_seg, err_badtree, err_noent, err_perm, err_rc}), 64'(x.err));
                chk(pa == x.pa, {t, " pa"}, pa, x.pa);
                chk(reads == int'(x.reads), {t, " reads"}, 64'(reads), 64'(x.reads));
            end
            done_cnt++;
            reads = 0;
        end
    end

    task automatic issue(input logic [63:0] ea, input logic priv, ifetch, store,
                         input logic [4:0] tb, input logic [4:0] sz);
        @(negedge clk);
        while (!req_ready) @(negedge clk);
        req_ea = ea; req_priv = priv; req_ifetch = ifetch; req_store = store;
        root_base = ROOT; root_tree_hi = tb[4:3]; root_tree_lo = tb[2:0]; root_size = sz;
        req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic walk(input string tag, input logic [63:0] ea, input logic priv, ifetch, store,
                        input logic [4:0] tb, input logic [4:0] sz);
        exp_q.push_back(model(ea, priv, ifetch, store, tb, sz));
        tag_q.push_back(tag);
        push_cnt++;
        issue(ea, priv, ifetch, store, tb, sz);
        while (exp_q.size() != 0) @(negedge clk);
    endtask

    task automatic two_level(input logic [63:0] leaf_e, input logic [4:0] nls);
        mem_m.delete();
        mem_m[ROOT + 8 * 64'(EA[30:22])] = dir(L2, nls);
        mem_m[L2 + 8 * 64'(EA[21:12])]   = leaf_e;
    endtask

    task automatic summary;
        $display("%0d/%0d checks passed", total - fails, total);
    endtask

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (150000) @(posedge clk);
        chk(1'b0, "R9 watchdog expired", 64'd0, 64'd1);
        summary();
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R11 reset state
        chk(req_ready == 1'b1, "R11 ready", 64'(req_ready), 64'd1);
        chk(done == 1'b0, "R11 done", 64'(done), 64'd0);
        chk(mem_req == 1'b0, "R11 mem_req", 64'(mem_req), 64'd0);

        // R8 two-level data load, literal result and R3 first address
        two_level(leaf(45'hABCDE, 1, 0, 2'b00, 4'b0100), 5'd10);
        walk("R8 load", EA, 1, 0, 0, 5'd0, 5'd9);
        two_level(leaf(45'hABCDE, 1, 0, 2'b00, 4'b0100), 5'd10);
        exp_q.push_back('{err: 5'b0, pa: 64'hABCD_E678, reads: 8'd2});
        tag_q.push_back("R8 literal");
        push_cnt++;
        issue(EA, 1, 0, 0, 5'd0, 5'd9);
        while (exp_q.size() != 0) @(negedge clk);
        chk(first_addr == 64'h1_0240, "R3 root entry address", first_addr, 64'h1_0240);

        // R6 store with read-only rights
        two_level(leaf(45'h12, 1, 1, 2'b00, 4'b0100), 5'd10);
        walk("R6 store read-only", EA, 1, 0, 1, 5'd0, 5'd9);
        // R7 store with write right but change clear
        two_level(leaf(45'h12, 1, 0, 2'b00, 4'b0010), 5'd10);
        walk("R7 store change clear", EA, 1, 0, 1, 5'd0, 5'd9);
        // R7 precedence: privileged-only page, user access, reference clear
        two_level(leaf(45'h12, 0, 0, 2'b00, 4'b1110), 5'd10);
        walk("R7 perm over rc", EA, 0, 0, 0, 5'd0, 5'd9);
        // R7 load with reference clear
        two_level(leaf(45'h12, 0, 1, 2'b00, 4'b0100), 5'd10);
        walk("R7 ref clear", EA, 1, 0, 0, 5'd0, 5'd9);
        // R6 user access to privileged-only page
        two_level(leaf(45'h12, 1, 1, 2'b00, 4'b1110), 5'd10);
        walk("R6 user on priv page", EA, 0, 0, 0, 5'd0, 5'd9);
        // R6 user access to open page succeeds
        two_level(leaf(45'h77, 1, 1, 2'b00, 4'b0110), 5'd10);
        walk("R6 user open page", EA, 0, 0, 1, 5'd0, 5'd9);

        // R10 slower memory from here on
        lat = 3;
        // R6 fetch on cache-inhibited page, then on normal page
        two_level(leaf(45'h55, 1, 0, 2'b10, 4'b0001), 5'd10);
        walk("R6 fetch inhibited", EA, 1, 1, 0, 5'd0, 5'd9);
        two_level(leaf(45'h55, 1, 0, 2'b00, 4'b0001), 5'd10);
        walk("R10 fetch slow memory", EA, 1, 1, 0, 5'd0, 5'd9);

        // R4 invalid root entry and invalid second-level entry
        mem_m.delete();
        walk("R4 root invalid", EA, 1, 0, 0, 5'd0, 5'd9);
        two_level(64'h0, 5'd10);
        walk("R4 leaf invalid", EA, 1, 0, 0, 5'd0, 5'd9);

        // R8 leaf at root level keeps 22 offset bits
        mem_m.delete();
        mem_m[ROOT + 8 * 64'(EA[30:22])] = leaf(45'h40000, 1, 1, 2'b00, 4'b0110);
        exp_q.push_back('{err: 5'b0, pa: 64'h4034_5678, reads: 8'd1});
        tag_q.push_back("R8 large page");
        push_cnt++;
        issue(EA, 1, 0, 0, 5'd0, 5'd9);
        while (exp_q.size() != 0) @(negedge clk);

        lat = 0;
        // R1 segment checks
        walk("R1 sign mismatch", 64'h8000_0000_0000_1000, 1, 0, 0, 5'd0, 5'd9);
        walk("R1 bit above span", 64'h0000_0100_0000_0000, 1, 0, 0, 5'd0, 5'd9);
        mem_m.delete();
        walk("R1 full span accepted", 64'h0000_0100_0000_0000, 1, 0, 0, 5'd31, 5'd16);
        walk("R1 both sign bits set", 64'hC000_0000_0000_0000, 1, 0, 0, 5'd31, 5'd16);

        // R2 root size limits
        walk("R2 root size small", EA, 1, 0, 0, 5'd0, 5'd4);
        walk("R2 root size large", EA, 1, 0, 0, 5'd0, 5'd17);
        // R5 next-level size too large for remaining bits, and too small
        two_level(leaf(45'h1, 1, 1, 2'b00, 4'b0110), 5'd11);
        walk("R5 next size over", EA, 1, 0, 0, 5'd0, 5'd9);
        two_level(leaf(45'h1, 1, 1, 2'b00, 4'b0110), 5'd3);
        walk("R5 next size under", EA, 1, 0, 0, 5'd0, 5'd9);

        // R9 request while busy is ignored
        lat = 4;
        two_level(leaf(45'h99, 1, 1, 2'b00, 4'b0110), 5'd10);
        exp_q.push_back(model(EA, 1, 0, 0, 5'd0, 5'd9));
        tag_q.push_back("R9 busy first result");
        push_cnt++;
        issue(EA, 1, 0, 0, 5'd0, 5'd9);
        @(negedge clk);
        chk(req_ready == 1'b0, "R9 ready low while busy", 64'(req_ready), 64'd0);
        req_ea = 64'h8000_0000_0000_0000;
        req_valid = 1'b1;
        repeat (3) @(negedge clk);
        req_valid = 1'b0;
        while (exp_q.size() != 0) @(negedge clk);
        repeat (10) @(negedge clk);
        chk(done_cnt == push_cnt, "R9 one done per accepted request", 64'(done_cnt), 64'(push_cnt));

        summary();
        $finish;
    end
endmodule